// File: doc/BRIEF.md
# Tabular Prime Implicant Engine

This block takes a Boolean function of four variables, given as an ON-set mask and a don't-care mask, and finds every prime implicant by the tabulation method. It runs as a sequential engine. A start strobe captures both masks. The engine turns every ON or don't-care minterm into a zero-dash cube. It then works level by level: in each level it merges pairs of cubes that differ in one position, marks both source cubes as covered, and adds the merged cube to the next level. After each merge pass, it streams out the cubes of that level that were never covered. When a merge pass produces nothing new, it raises a one-cycle done pulse.

Cubes live in a bitmap indexed by the cube word {value, dash}. A cube added twice therefore takes one slot only. Merging visits one cube per cycle and probes all of its partner positions in parallel. A partner is the cube with the same dash mask and one more 1 in its value, which places it in the next group by count of ones. The state machine has four states:
- `S_IDLE` waits for start, then goes to `S_MERGE` and loads the masks.
- `S_MERGE` sweeps every cube slot once, then goes to `S_EMIT`.
- `S_EMIT` sweeps the slots again and offers each prime cube on the stream. At the end of the sweep it returns to `S_MERGE` for the next level if the pass grew the table, or goes to `S_FIN` if it did not.
- `S_FIN` pulses done and returns to `S_IDLE`.

Top module: `tpi_prime_engine`

## Requirements
- R1: After reset, pi_valid and done are low, and they stay low until a start strobe is seen.
- R2: A start strobe in the idle state captures on_mask and dc_mask. While the engine is busy, changes on these masks and any start strobe have no effect on the emitted stream or on the count of done pulses.
- R3: The stream carries, exactly once each, every prime implicant of ON ∪ DC that contains at least one ON minterm. Merging treats two cubes as partners only when their dash masks are equal and their values differ in exactly one bit.
- R4: A beat's pi_cube holds the value in bits [7:4] and the dash mask in bits [3:0]. Value bit i stands for bit i of the minterm index, where on_mask bit m is minterm m. Value bits under a dash are 0.
- R5: A cube that has been merged into a larger cube is never emitted.
- R6: Don't-care minterms join merging as if they were 1, so an emitted cube may span don't-care minterms.
- R7: A cube whose minterms are all don't-cares is not emitted.
- R8: Beats come out in increasing number of dashes. Within one dash count they come out in increasing numeric value of the 8-bit cube word.
- R9: A beat transfers on a cycle where pi_valid and pi_ready are both high. While pi_valid is high and pi_ready is low, pi_valid stays high and pi_cube stays unchanged.
- R10: done is high for exactly one cycle, after the last beat has been accepted, or after the sweeps if there are no beats. No beat follows it until the next start.
- R11: A function with no adjacent minterms emits each ON minterm as a zero-dash cube. An empty ON-set gives done with no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle |
| on_mask | input | 16 | ON-set, bit m is minterm m |
| dc_mask | input | 16 | Don't-care set, bit m is minterm m |
| pi_valid | output | 1 | A prime implicant is offered |
| pi_ready | input | 1 | Sink accepts the offered beat |
| pi_cube | output | 8 | {value, dash mask} of the offered cube |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest case to reach from the ports is a start strobe that arrives in the middle of a merge sweep, together with new masks. The engine must ignore both. The stimulus raises start with different masks about a hundred cycles into a run, then expects the stream computed for the first masks and a single done pulse. The second hard case is a cube made entirely of don't-cares that survives as a prime. This needs a lone don't-care minterm placed far from the ON-set, so the stimulus includes such a function next to one where don't-cares widen an ON cube. The stream is also throttled with irregular ready patterns, so that stalls land on every beat position.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

    // Engine control states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MERGE = 2'd1,
        S_EMIT  = 2'd2,
        S_FIN   = 2'd3
    } tpi_state_e;

endpackage

// File: rtl/tpi_merge_unit.sv
// Probes all merge partners of one cube in parallel.
// Cube word layout: {value[NVAR-1:0], dash[NVAR-1:0]}.
module tpi_merge_unit #(
    parameter int NVAR = 4
) (
    input  logic [2*NVAR-1:0]                 cube_idx,
    input  logic [$clog2(NVAR+1)-1:0]         level,
    input  logic [(1<<(2*NVAR))-1:0]          present,
    output logic                              eligible,
    output logic [NVAR-1:0]                   hit,
    output logic [NVAR-1:0][2*NVAR-1:0]       partner_idx,
    output logic [NVAR-1:0][2*NVAR-1:0]       merged_idx
);
    localparam int CW = 2 * NVAR;

    logic [NVAR-1:0] val;
    logic [NVAR-1:0] dsh;

    assign val = cube_idx[CW-1:NVAR];
    assign dsh = cube_idx[NVAR-1:0];

    // A slot takes part only if it is occupied, well formed and in this level
    assign eligible = present[cube_idx]
                   && ((val & dsh) == '0)
                   && ($countones(dsh) == int'(level));

    for (genvar j = 0; j < NVAR; j++) begin : g_pos
        localparam logic [NVAR-1:0] ONEHOT = {{(NVAR-1){1'b0}}, 1'b1} << j;
        // Partner: same dash mask, one more 1 in the value (next group)
        assign partner_idx[j] = {val | ONEHOT, dsh};
        assign merged_idx[j]  = {val, dsh | ONEHOT};
        assign hit[j] = eligible && !dsh[j] && !val[j] && present[partner_idx[j]];
    end

endmodule

// File: rtl/tpi_on_probe.sv
// Tells whether a cube spans at least one ON-set minterm.
module tpi_on_probe #(
    parameter int NVAR = 4
) (
    input  logic [2*NVAR-1:0]       cube_idx,
    input  logic [(1<<NVAR)-1:0]    on_set,
    output logic                    has_on
);
    localparam int CW    = 2 * NVAR;
    localparam int NMINT = 1 << NVAR;

    logic [NVAR-1:0] val;
    logic [NVAR-1:0] dsh;

    assign val = cube_idx[CW-1:NVAR];
    assign dsh = cube_idx[NVAR-1:0];

    always_comb begin
        has_on = 1'b0;
        for (int m = 0; m < NMINT; m++) begin
            if (((NVAR'(m) & ~dsh) == val) && on_set[m]) begin
                has_on = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tpi_cube_store.sv
// Occupancy and covered bitmaps over the full cube code space.
module tpi_cube_store #(
    parameter int NVAR = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [(1<<NVAR)-1:0]              load_set,
    input  logic                              apply,
    input  logic [2*NVAR-1:0]                 cube_idx,
    input  logic [NVAR-1:0]                   hit,
    input  logic [NVAR-1:0][2*NVAR-1:0]       partner_idx,
    input  logic [NVAR-1:0][2*NVAR-1:0]       merged_idx,
    output logic [(1<<(2*NVAR))-1:0]          present,
    output logic [(1<<(2*NVAR))-1:0]          covered
);
    localparam int NMINT = 1 << NVAR;
    localparam int NSLOT = 1 << (2 * NVAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present <= '0;
            covered <= '0;
        end else if (load) begin
            // Level zero: one dash-free cube per ON or don't-care minterm
            for (int c = 0; c < NSLOT; c++) begin
                present[c] <= ((c % NMINT) == 0) && load_set[c / NMINT];
            end
            covered <= '0;
        end else if (apply) begin
            for (int j = 0; j < NVAR; j++) begin
                if (hit[j]) begin
                    covered[cube_idx]       <= 1'b1;
                    covered[partner_idx[j]] <= 1'b1;
                    present[merged_idx[j]]  <= 1'b1;  // bitmap: no duplicate slot
                end
            end
        end
    end

    // Covered marks are only ever added within a run
    AST_COVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((covered & $past(covered)) == $past(covered)))
        else $error("covered flag cleared mid-run"); // R5

endmodule

// File: rtl/tpi_prime_engine.sv
module tpi_prime_engine #(
    parameter int NVAR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [(1<<NVAR)-1:0]    on_mask,
    input  logic [(1<<NVAR)-1:0]    dc_mask,
    output logic                    pi_valid,
    input  logic                    pi_ready,
    output logic [2*NVAR-1:0]       pi_cube,
    output logic                    done
);
    import tpi_pkg::*;

    localparam int CW    = 2 * NVAR;
    localparam int NMINT = 1 << NVAR;
    localparam int NSLOT = 1 << CW;
    localparam int LW    = $clog2(NVAR + 1);

    tpi_state_e              state_q, state_d;
    logic [CW-1:0]           idx_q, idx_d;
    logic [LW-1:0]           level_q, level_d;
    logic                    grew_q, grew_d;
    logic [NMINT-1:0]        on_q, on_d;

    logic                    load, apply;
    logic                    eligible, has_on, emit_cand;
    logic [NVAR-1:0]         hit;
    logic [NVAR-1:0][CW-1:0] partner_idx;
    logic [NVAR-1:0][CW-1:0] merged_idx;
    logic [NSLOT-1:0]        present, covered;

    tpi_merge_unit #(.NVAR(NVAR)) u_merge (
        .cube_idx    (idx_q),
        .level       (level_q),
        .present     (present),
        .eligible    (eligible),
        .hit         (hit),
        .partner_idx (partner_idx),
        .merged_idx  (merged_idx)
    );

    tpi_cube_store #(.NVAR(NVAR)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_set    (on_mask | dc_mask),
        .apply       (apply),
        .cube_idx    (idx_q),
        .hit         (hit),
        .partner_idx (partner_idx),
        .merged_idx  (merged_idx),
        .present     (present),
        .covered     (covered)
    );

    tpi_on_probe #(.NVAR(NVAR)) u_on (
        .cube_idx (idx_q),
        .on_set   (on_q),
        .has_on   (has_on)
    );

    // Prime in this level, not made of don't-cares alone
    assign emit_cand = eligible && !covered[idx_q] && has_on;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        level_d = level_q;
        grew_d  = grew_q;
        on_d    = on_q;
        load    = 1'b0;
        apply   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_MERGE;
                    load    = 1'b1;
                    idx_d   = '0;
                    level_d = '0;
                    grew_d  = 1'b0;
                    on_d    = on_mask;
                end
            end
            S_MERGE: begin
                apply = 1'b1;
                idx_d = idx_q + 1'b1;
                if (|hit) begin
                    grew_d = 1'b1;
                end
                if (&idx_q) begin
                    state_d = S_EMIT;
                end
            end
            S_EMIT: begin
                if (!emit_cand || pi_ready) begin
                    idx_d = idx_q + 1'b1;
                    if (&idx_q) begin
                        if (grew_q && (level_q < LW'(NVAR))) begin
                            state_d = S_MERGE;
                            level_d = level_q + 1'b1;
                            grew_d  = 1'b0;
                        end else begin
                            state_d = S_FIN;
                        end
                    end
                end
            end
            S_FIN: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            level_q <= '0;
            grew_q  <= 1'b0;
            on_q    <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            level_q <= level_d;
            grew_q  <= grew_d;
            on_q    <= on_d;
        end
    end

    // Outputs
    always_comb begin
        pi_valid = (state_q == S_EMIT) && emit_cand;
        pi_cube  = pi_valid ? idx_q : '0;
        done     = (state_q == S_FIN);
    end

    AST_DASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pi_valid |-> ((pi_cube[CW-1:NVAR] & pi_cube[NVAR-1:0]) == '0))
        else $error("value bit set under dash"); // R4

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_valid && !pi_ready) |=> (pi_valid && $stable(pi_cube)))
        else $error("beat changed while stalled"); // R9

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R10

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> (on_q == $past(on_q)))
        else $error("busy start changed captured set"); // R2

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT && state_d == S_MERGE) |=> (level_q == LW'($past(level_q) + 1)))
        else $error("level skipped"); // R8

endmodule

// File: tb/sim_tpi_prime_engine.sv
module sim_tpi_prime_engine;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] on_mask = '0;
    logic [15:0] dc_mask = '0;
    logic        pi_ready = 1'b0;
    logic        pi_valid;
    logic [7:0]  pi_cube;
    logic        done;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] exp_q [0:127];
    int         exp_n;
    logic [7:0] got_q [0:127];
    int         got_n;

    always #(CLK_P/2) clk = ~clk;

    tpi_prime_engine #(.NVAR(4)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .on_mask  (on_mask),
        .dc_mask  (dc_mask),
        .pi_valid (pi_valid),
        .pi_ready (pi_ready),
        .pi_cube  (pi_cube),
        .done     (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------- reference model from the requirements ----------
    function automatic bit is_impl(logic [3:0] v, logic [3:0] d, logic [15:0] s);
        for (int m = 0; m < 16; m++) begin
            if (((4'(m) & ~d) == v) && !s[m]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit spans_on(logic [3:0] v, logic [3:0] d, logic [15:0] s);
        for (int m = 0; m < 16; m++) begin
            if (((4'(m) & ~d) == v) && s[m]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit is_prime(logic [3:0] v, logic [3:0] d, logic [15:0] s);
        if ((v & d) != 4'h0 || !is_impl(v, d, s)) return 1'b0;
        for (int j = 0; j < 4; j++) begin
            if (!d[j] && is_impl(v & ~(4'h1 << j), d | (4'h1 << j), s)) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic build_expect(input logic [15:0] on, input logic [15:0] dc);
        exp_n = 0;
        for (int lvl = 0; lvl <= 4; lvl++) begin
            for (int w = 0; w < 256; w++) begin
                logic [7:0] cw;
                cw = 8'(w);
                if ($countones(cw[3:0]) == lvl && is_prime(cw[7:4], cw[3:0], on | dc)
                    && spans_on(cw[7:4], cw[3:0], on)) begin
                    exp_q[exp_n] = cw;
                    exp_n++;
                end
            end
        end
    endtask

    // ---------- one run: drive, collect, compare ----------
    task automatic run_stream(input string tag, input logic [15:0] on, input logic [15:0] dc,
                              input int rmode, input int busy_at,
                              input logic [15:0] alt_on, input logic [15:0] alt_dc);
        int   cyc;
        bit   stall;
        logic [7:0] last_cube;
        bit   seen_done;
        build_expect(on, dc);
        got_n = 0;
        @(negedge clk);
        on_mask = on;
        dc_mask = dc;
        start   = 1'b1;
        cyc = 0;
        stall = 1'b0;
        last_cube = '0;
        seen_done = 1'b0;
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == busy_at);
            if (cyc == busy_at) begin
                on_mask = alt_on;
                dc_mask = alt_dc;
            end
            case (rmode)
                1:       pi_ready = (cyc % 3 == 0);
                2:       pi_ready = (cyc % 7 < 3);
                default: pi_ready = 1'b1;
            endcase
            if (stall) begin
                chk(pi_valid && pi_cube == last_cube, "R9", {tag, " stalled beat held"},
                    int'({pi_valid, pi_cube}), int'({1'b1, last_cube}));
            end
            if (pi_valid && pi_ready && got_n < 128) begin
                got_q[got_n] = pi_cube;
                got_n++;
            end
            stall = pi_valid && !pi_ready;
            last_cube = pi_cube;
            if (done) begin
                seen_done = 1'b1;
                chk(!pi_valid, "R10", {tag, " no beat with done"}, int'(pi_valid), 0);
            end
        end
        start = 1'b0;
        chk(seen_done, "R10", {tag, " done reached"}, int'(seen_done), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done && !pi_valid, "R10", {tag, " quiet after done"},
                int'({done, pi_valid}), 0);
        end
        chk(got_n == exp_n, "R3", {tag, " beat count"}, got_n, exp_n);
        for (int k = 0; k < got_n && k < exp_n; k++) begin
            chk(got_q[k] == exp_q[k], "R3", {tag, " beat content"}, int'(got_q[k]), int'(exp_q[k]));
        end
        for (int k = 0; k < got_n; k++) begin
            chk((got_q[k][7:4] & got_q[k][3:0]) == 4'h0, "R4", {tag, " value under dash"},
                int'(got_q[k]), int'(got_q[k] & 8'h0F));
            chk(is_prime(got_q[k][7:4], got_q[k][3:0], on | dc), "R5", {tag, " beat is prime"},
                int'(got_q[k]), 1);
            chk(spans_on(got_q[k][7:4], got_q[k][3:0], on), "R7", {tag, " beat spans ON"},
                int'(got_q[k]), 1);
            if (k > 0) begin
                chk(($countones(got_q[k-1][3:0]) * 256 + int'(got_q[k-1]))
                    < ($countones(got_q[k][3:0]) * 256 + int'(got_q[k])),
                    "R8", {tag, " beat order"}, int'(got_q[k]), int'(got_q[k-1]));
            end
        end
    endtask

    // ---------- scenarios ----------
    task automatic t_reset;
        chk(!pi_valid && !done, "R1", "outputs in reset", int'({pi_valid, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!pi_valid && !done, "R1", "idle without start", int'({pi_valid, done}), 0);
        end
    endtask

    task automatic t_textbook;
        run_stream("textbook", 16'hE4A5, 16'h0000, 0, 0, 16'h0, 16'h0);
        chk(got_n == 5, "R3", "textbook prime count", got_n, 5);
    endtask

    task automatic t_dontcare;
        bit found;
        run_stream("dontcare", 16'h039F, 16'hFC00, 0, 0, 16'h0, 16'h0);
        found = 1'b0;
        for (int k = 0; k < got_n; k++) if (got_q[k] == 8'h0B) found = 1'b1;
        chk(found, "R6", "x-bar cube widened by don't-cares", int'(found), 1);
    endtask

    task automatic t_dc_only;
        run_stream("dc_only", 16'h0001, 16'h8000, 0, 0, 16'h0, 16'h0);
        chk(got_n == 1 && got_q[0] == 8'h00, "R7", "lone don't-care cube dropped",
            int'({got_n[7:0], got_q[0]}), 16'h0100);
        run_stream("all_dc", 16'h0000, 16'hFFFF, 0, 0, 16'h0, 16'h0);
        chk(got_n == 0, "R7", "all don't-care function", got_n, 0);
    endtask

    task automatic t_backpressure;
        run_stream("stall3", 16'hE4A5, 16'h0000, 1, 0, 16'h0, 16'h0);
        run_stream("stall7", 16'h039F, 16'hFC00, 2, 0, 16'h0, 16'h0);
    endtask

    task automatic t_edges;
        run_stream("empty", 16'h0000, 16'h0000, 0, 0, 16'h0, 16'h0);
        chk(got_n == 0, "R11", "empty ON-set", got_n, 0);
        run_stream("full", 16'hFFFF, 16'h0000, 0, 0, 16'h0, 16'h0);
        chk(got_n == 1 && got_q[0] == 8'h0F, "R3", "full function one cube",
            int'({got_n[7:0], got_q[0]}), 16'h010F);
        run_stream("single", 16'h0200, 16'h0000, 0, 0, 16'h0, 16'h0);
        chk(got_n == 1 && got_q[0] == 8'h90, "R11", "single minterm",
            int'({got_n[7:0], got_q[0]}), 16'h0190);
        run_stream("parity", 16'h6996, 16'h0000, 2, 0, 16'h0, 16'h0);
        chk(got_n == 8, "R11", "parity no merges", got_n, 8);
    endtask

    task automatic t_busy_start;
        run_stream("busy", 16'hE4A5, 16'h0000, 0, 100, 16'h00FF, 16'h0F00);
        chk(got_n == exp_n, "R2", "busy start ignored", got_n, exp_n);
    endtask

    task automatic t_mixed;
        logic [31:0] lf;
        lf = 32'h1D87_2A4B;
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 32; s++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_stream("mixed", lf[15:0], lf[31:16] & ~lf[15:0] & {lf[7:0], lf[15:8]},
                       r % 3, 0, 16'h0, 16'h0);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_textbook();
        t_dontcare();
        t_dc_only();
        t_backpressure();
        t_edges();
        t_busy_start();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule